// File: doc/BRIEF.md
# Run-length configuration bit expander

This block turns a stream of compressed configuration bytes into the single-bit serial stream that a configuration sequencer shifts into a programmable device. Bytes arrive on a valid/ready input. Bits leave on a valid/ready output, and the sink may stall that output at any time. In compressed mode, each byte is a code. A code stands for a run of ones or a run of zeros, with or without a closing bit of the opposite value. The boundaries between code classes are set by the parameter `MAX_ONES`. Before the first payload bit, the block sends a fixed 16-bit prefix, 0xFF then 0x20, MSB first.

When `raw_mode` is high, the block sends no prefix and does no expansion. Each byte goes out as eight bits, most significant bit first. The `idle` output is high once the prefix has finished, no code is being expanded and the output register is empty. Together with an end-of-image flag from upstream, the sequencer uses `idle` to tell that the stream has been fully delivered.

Top module: `rle_bit_expander`

## Requirements
- R1: While `rst` is high, `out_valid` is low. In the first cycle after reset in compressed mode, `in_ready` and `idle` are both low. In the first cycle after reset in raw mode, `idle` and `in_ready` are both high and `out_valid` is low.
- R2: In compressed mode, exactly 16 bits are delivered after reset and before the first byte is accepted. They are 1111_1111_0010_0000, in that order, which is 0xFF then 0x20 with the MSB first.
- R3: In compressed mode, a code n with 1 ≤ n ≤ MAX_ONES (default 226) yields n one-bits and then one zero-bit.
- R4: The code MAX_ONES+1 (227 by default) yields MAX_ONES one-bits and no closing bit.
- R5: A code n with MAX_ONES+2 ≤ n ≤ 254 yields n−(MAX_ONES+2) zero-bits and then one one-bit. With the default, 228 yields a lone one and 254 yields 26 zeros and a one.
- R6: The code 255 yields a single one-bit.
- R7: The code 0 yields no bits. The block is ready for the next byte in the cycle that follows its acceptance.
- R8: In raw mode, no prefix is sent. Each accepted byte yields exactly 8 bits, bit 7 first and bit 0 last.
- R9: `in_ready` stays low from the acceptance of a code that yields bits until its last bit has been accepted downstream. It is never high while `out_valid` is high.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` keeps its value in the next cycle.
- R11: `idle` is high only when the prefix is done, no code is pending and `out_valid` is low. It goes high once all bits of the last accepted code have been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_mode | input | 1 | 1 = send bytes unexpanded, MSB first, with no prefix; hold stable outside reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes the byte in this cycle |
| in_byte | input | 8 | Compressed code or raw byte |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Sink takes the bit in this cycle |
| out_bit | output | 1 | Serial output bit |
| idle | output | 1 | Prefix done, nothing pending, output empty |

## Verification
The checks count output handshakes between byte acceptances. They therefore assume three things about the inputs: `raw_mode` changes only while reset is high, `in_byte` stays stable while `in_valid` waits for `in_ready`, and `MAX_ONES` is at most 252 so that every code class exists. The stimulus changes the mode only inside a reset pulse, and it holds each byte until the handshake. It stalls the sink through a pseudo-random `out_ready` pattern, so the hold rule is exercised on many bits. The stimulus sweeps all 256 byte values in both modes and compares each emitted bit sequence with one computed from the code rules.

// File: rtl/rle_pkg.sv
package rle_pkg;

  localparam int CODE_W = 8;

  // One decoded compressed code: a run of identical bits, then an optional closing bit.
  typedef struct packed {
    logic [CODE_W-1:0] run_len;
    logic              run_bit;
    logic              tail_en;
    logic              tail_bit;
  } rle_code_t;

endpackage

// File: rtl/rle_code_decoder.sv
module rle_code_decoder
  import rle_pkg::*;
#(
  parameter int MAX_ONES = 226   // must stay at or below 252
) (
  input  logic [CODE_W-1:0] code,
  output rle_code_t         dec
);

  localparam logic [CODE_W-1:0] LIM_ONES  = CODE_W'(MAX_ONES);
  localparam logic [CODE_W-1:0] LIM_BARE  = CODE_W'(MAX_ONES + 1);
  localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(MAX_ONES + 2);
  localparam logic [CODE_W-1:0] LONE_ONE  = '1;

  always_comb begin
    dec = '0;
    if (code == '0) begin
      dec = '0;
    end else if (code <= LIM_ONES) begin
      dec.run_len  = code;
      dec.run_bit  = 1'b1;
      dec.tail_en  = 1'b1;
      dec.tail_bit = 1'b0;
    end else if (code == LIM_BARE) begin
      dec.run_len  = LIM_ONES;
      dec.run_bit  = 1'b1;
      dec.tail_en  = 1'b0;
    end else if (code == LONE_ONE) begin
      dec.run_len  = '0;
      dec.tail_en  = 1'b1;
      dec.tail_bit = 1'b1;
    end else begin
      dec.run_len  = code - ZERO_BASE;
      dec.run_bit  = 1'b0;
      dec.tail_en  = 1'b1;
      dec.tail_bit = 1'b1;
    end
  end

endmodule

// File: rtl/rle_prefix_gen.sv
module rle_prefix_gen #(
  parameter int               PFX_W   = 16,
  parameter logic [PFX_W-1:0] PFX_VAL = 16'hFF20
) (
  input  logic clk,
  input  logic rst,
  input  logic skip,
  input  logic take,
  output logic have,
  output logic bit_o,
  output logic done
);

  localparam int PFX_CW = $clog2(PFX_W + 1);

  logic [PFX_CW-1:0] left_q;
  logic [PFX_W-1:0]  sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= PFX_CW'(PFX_W);
      sh_q   <= PFX_VAL;
    end else if (take && have) begin
      left_q <= left_q - 1'b1;
      sh_q   <= {sh_q[PFX_W-2:0], 1'b0};
    end
  end

  assign have  = !skip && (left_q != '0);
  assign bit_o = sh_q[PFX_W-1];
  assign done  = skip || (left_q == '0);

endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
  import rle_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              raw_load,
  input  logic [CODE_W-1:0] byte_i,
  input  rle_code_t         dec,
  input  logic              take,
  output logic              have,
  output logic              bit_o
);

  localparam int RAW_CW = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] raw_sh_q;
  logic [RAW_CW-1:0] raw_left_q;
  logic [CODE_W-1:0] run_left_q;
  logic              run_bit_q;
  logic              tail_en_q;
  logic              tail_bit_q;

  logic raw_act, run_act;

  assign raw_act = (raw_left_q != '0);
  assign run_act = (run_left_q != '0);
  assign have    = raw_act || run_act || tail_en_q;

  always_comb begin
    if (raw_act)      bit_o = raw_sh_q[CODE_W-1];
    else if (run_act) bit_o = run_bit_q;
    else              bit_o = tail_bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_sh_q   <= '0;
      raw_left_q <= '0;
      run_left_q <= '0;
      run_bit_q  <= 1'b0;
      tail_en_q  <= 1'b0;
      tail_bit_q <= 1'b0;
    end else if (load) begin
      if (raw_load) begin
        raw_sh_q   <= byte_i;
        raw_left_q <= RAW_CW'(CODE_W);
      end else begin
        run_left_q <= dec.run_len;
        run_bit_q  <= dec.run_bit;
        tail_en_q  <= dec.tail_en;
        tail_bit_q <= dec.tail_bit;
      end
    end else if (take) begin
      if (raw_act) begin
        raw_left_q <= raw_left_q - 1'b1;
        raw_sh_q   <= {raw_sh_q[CODE_W-2:0], 1'b0};
      end else if (run_act) begin
        run_left_q <= run_left_q - 1'b1;
      end else begin
        tail_en_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rle_out_reg.sv
module rle_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic src_have,
  input  logic src_bit,
  input  logic out_ready,
  output logic take,
  output logic out_valid,
  output logic out_bit
);

  logic adv;

  assign adv  = !out_valid || out_ready;
  assign take = adv && src_have;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (adv) begin
      out_valid <= src_have;
      if (src_have) out_bit <= src_bit;
    end
  end

endmodule

// File: rtl/rle_bit_expander.sv
module rle_bit_expander
  import rle_pkg::*;
#(
  parameter int               MAX_ONES = 226,
  parameter int               PFX_W    = 16,
  parameter logic [PFX_W-1:0] PFX_VAL  = 16'hFF20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic              idle
);

  rle_code_t dec;
  logic pfx_have, pfx_bit, pfx_done, pfx_take;
  logic eng_have, eng_bit, eng_take, eng_load;
  logic src_have, src_bit, take;
  logic drained;

  rle_code_decoder #(.MAX_ONES(MAX_ONES)) u_dec (
    .code (in_byte),
    .dec  (dec)
  );

  rle_prefix_gen #(.PFX_W(PFX_W), .PFX_VAL(PFX_VAL)) u_pfx (
    .clk   (clk),
    .rst   (rst),
    .skip  (raw_mode),
    .take  (pfx_take),
    .have  (pfx_have),
    .bit_o (pfx_bit),
    .done  (pfx_done)
  );

  rle_run_engine u_eng (
    .clk      (clk),
    .rst      (rst),
    .load     (eng_load),
    .raw_load (raw_mode),
    .byte_i   (in_byte),
    .dec      (dec),
    .take     (eng_take),
    .have     (eng_have),
    .bit_o    (eng_bit)
  );

  // Prefix has priority; the engine can only hold bits once the prefix is done.
  assign src_have = pfx_have || eng_have;
  assign src_bit  = pfx_have ? pfx_bit : eng_bit;
  assign pfx_take = take && pfx_have;
  assign eng_take = take && !pfx_have;

  rle_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .src_have  (src_have),
    .src_bit   (src_bit),
    .out_ready (out_ready),
    .take      (take),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  assign drained  = pfx_done && !eng_have && !out_valid;
  assign in_ready = drained;
  assign idle     = drained;
  assign eng_load = in_valid && drained;

endmodule

// File: rtl/rle_bit_expander_chk.sv
module rle_bit_expander_chk (
  input logic       clk,
  input logic       rst,
  input logic       raw_mode,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_bit,
  input logic       idle
);

  logic [8:0] hs_cnt;
  logic       first_done;
  logic [7:0] last_code;
  logic       acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_cnt     <= '0;
      first_done <= 1'b0;
      last_code  <= '0;
    end else if (acc) begin
      hs_cnt     <= '0;
      first_done <= 1'b1;
      last_code  <= in_byte;
    end else if (out_valid && out_ready && hs_cnt != '1) begin
      hs_cnt     <= hs_cnt + 1'b1;
    end
  end

  assert_prefix_len_R2: assert property (@(posedge clk) disable iff (rst)
    (!raw_mode && acc && !first_done) |-> (hs_cnt == 9'd16));

  assert_raw_no_prefix_R8: assert property (@(posedge clk) disable iff (rst)
    (raw_mode && acc && !first_done) |-> (hs_cnt == 9'd0));

  assert_raw_eight_R8: assert property (@(posedge clk) disable iff (rst)
    (raw_mode && acc && first_done) |-> (hs_cnt == 9'd8));

  assert_lone_one_R6: assert property (@(posedge clk) disable iff (rst)
    (!raw_mode && acc && first_done && last_code == 8'hFF) |-> (hs_cnt == 9'd1));

  assert_empty_code_R7: assert property (@(posedge clk) disable iff (rst)
    (!raw_mode && acc && first_done && last_code == 8'h00) |-> (hs_cnt == 9'd0));

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  assert_idle_empty_R11: assert property (@(posedge clk) disable iff (rst)
    idle |-> !out_valid);

endmodule

bind rle_bit_expander rle_bit_expander_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .raw_mode  (raw_mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_byte   (in_byte),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .idle      (idle)
);

// File: tb/test_rle_bit_expander.sv
`timescale 1ns/1ps
module test_rle_bit_expander;

  localparam int MAXO = 226;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, out_bit, idle;

  always #10 clk = ~clk;   // 50 MHz

  rle_bit_expander #(.MAX_ONES(MAXO)) i_rle_bit_expander (
    .clk       (clk),
    .rst       (rst),
    .raw_mode  (raw_mode),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .idle      (idle)
  );

  int checks = 0, fails = 0;
  int hold_checks = 0, hold_fails = 0;
  bit finished = 1'b0;
  bit got_q[$];
  bit exp_q[$];

  // Sink: pseudo-random ready, bit capture and hold check (R10), all at the falling edge.
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 1'b0;
  bit prev_bit = 1'b0;
  always @(negedge clk) begin
    if (prev_stall) begin
      hold_checks++;
      if (!out_valid || out_bit != prev_bit) begin
        hold_fails++;
        $display("FAIL R10 hold: valid=%0d bit=%0d expected valid=1 bit=%0d", out_valid, out_bit, prev_bit);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rst ? 1'b0 : (lfsr[1:0] != 2'b00);
    prev_stall = out_valid && !out_ready;
    prev_bit = out_bit;
    if (out_valid && out_ready) got_q.push_back(out_bit);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_byte = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!idle) @(negedge clk);
  endtask

  task automatic build_exp(input int code, input bit raw);
    exp_q.delete();
    if (raw) begin
      for (int i = 7; i >= 0; i--) exp_q.push_back(code[i]);
    end else if (code == 0) begin
    end else if (code <= MAXO) begin
      for (int i = 0; i < code; i++) exp_q.push_back(1'b1);
      exp_q.push_back(1'b0);
    end else if (code == MAXO + 1) begin
      for (int i = 0; i < MAXO; i++) exp_q.push_back(1'b1);
    end else if (code == 255) begin
      exp_q.push_back(1'b1);
    end else begin
      for (int i = 0; i < code - (MAXO + 2); i++) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
    end
  endtask

  // Compare captured bits from index base against exp_q.
  task automatic cmp_seq(input string req, input int base, input int code);
    int n = got_q.size() - base;
    int bad = -1;
    checks++;
    if (n == exp_q.size()) begin
      for (int i = 0; i < n; i++)
        if (bad < 0 && got_q[base+i] != exp_q[i]) bad = i;
    end
    if (n != exp_q.size() || bad >= 0) begin
      fails++;
      $display("FAIL %s code=%0d: actual len=%0d expected len=%0d first mismatch=%0d",
               req, code, n, exp_q.size(), bad);
    end
  endtask

  function automatic string req_of(input int code);
    if (code == 0) return "R7";
    if (code <= MAXO) return "R3";
    if (code == MAXO + 1) return "R4";
    if (code == 255) return "R6";
    return "R5";
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed",
               (checks + hold_checks) - (fails + hold_fails), checks + hold_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int base;
    // Compressed mode reset (R1)
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 in_ready after reset", in_ready, 0);
    chk("R1 idle after reset", idle, 0);
    // Prefix (R2)
    wait_idle();
    exp_q.delete();
    for (int i = 15; i >= 0; i--) exp_q.push_back(((16'hFF20 >> i) & 1) != 0);
    cmp_seq("R2 prefix", 0, -1);
    chk("R11 idle after prefix", idle, 1);
    // Sweep every code (R3 R4 R5 R6 R7 R9 R11)
    for (int c = 0; c < 256; c++) begin
      base = got_q.size();
      send(8'(c));
      if (c == 0) begin
        chk("R7 ready after empty code", in_ready, 1);
      end else begin
        chk("R9 in_ready low while expanding", in_ready, 0);
        chk("R11 idle low while expanding", idle, 0);
      end
      wait_idle();
      build_exp(c, 1'b0);
      cmp_seq(req_of(c), base, c);
    end
    // Raw mode (R8, R1)
    @(negedge clk);
    rst = 1'b1;
    raw_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset raw", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after raw reset", idle, 1);
    chk("R1 in_ready after raw reset", in_ready, 1);
    chk("R1 out_valid after raw reset", out_valid, 0);
    for (int c = 0; c < 256; c++) begin
      base = got_q.size();
      send(8'(c));
      chk("R9 raw in_ready low while shifting", in_ready, 0);
      wait_idle();
      build_exp(c, 1'b1);
      cmp_seq("R8 raw byte", base, c);
    end
    summary();
  end

endmodule